// File: doc/BRIEF.md
# Turn Signal Flasher Lamp Controller

This block turns debounced driver controls into four lamp drives for a vehicle. It stores an emergency-flasher state, a left-turn state, a right-turn state and a brake state. One-cycle press events from an upstream debouncer change these states. A level input sets the brake state.

A shared flash timer advances on a slow timing strobe. It alternates between a lit phase and a dark phase whenever any flashing source is active. The lamp stage works in a fixed order. First, each lamp is enabled by its flashing sources. Next, the flash phase gates those enables. Last, the brake forces the rear pair on. The four lamp outputs are active-low. A separate active-high driver enable is raised only while some lamp is actually lit.

The block sits between the debouncer and the lamp power stage. It adds no buffering at either edge. The lamp outputs follow registered state within the same cycle.

Top module: `turn_flasher_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all four states are clear, the flash phase is dark, every lamp output is 1 (off) and `drv_en` is 0.
- R2: Each cycle with `ev_emg` high inverts the emergency state, taking effect at the next clock edge.
- R3: `ev_left` sets the left-turn state and `ev_right` sets the right-turn state. `ev_cancel` clears both turn states and takes priority over a press in the same cycle.
- R4: The brake state equals `brake_in` as sampled at the previous clock edge.
- R5: Emergency enables all four lamps. Left enables front-left and rear-left. Right enables front-right and rear-right.
- R6: While the flash phase is dark, every lamp enabled only by a flashing source is off.
- R7: While the brake state is set, both rear lamps are lit in either flash phase.
- R8: With no emergency or turn state active, the timer is held in the dark phase with its count reloaded to `LIT_TICKS`. The first dark interval after a source turns on therefore lasts `LIT_TICKS` strobes.
- R9: Once running, the lit phase lasts `LIT_TICKS` strobe cycles and the dark phase lasts `DARK_TICKS` strobe cycles. The phase never changes in an active cycle without `tick`.
- R10: Lamp outputs are active-low (0 means lit). `drv_en` is 1 exactly when at least one lamp output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow timing strobe, one cycle wide |
| ev_emg | input | 1 | Emergency button press event |
| ev_left | input | 1 | Left turn press event |
| ev_right | input | 1 | Right turn press event |
| ev_cancel | input | 1 | Qualified turn cancel event |
| brake_in | input | 1 | Debounced brake pedal level |
| lamp_fl_n | output | 1 | Front-left lamp, active-low |
| lamp_fr_n | output | 1 | Front-right lamp, active-low |
| lamp_rl_n | output | 1 | Rear-left lamp, active-low |
| lamp_rr_n | output | 1 | Rear-right lamp, active-low |
| drv_en | output | 1 | Lamp driver enable, active-high |

## Verification
Two functions can act in the same cycle: the brake override and the dark phase of the flash timer. The bench first holds a left turn flashing, then raises the brake. It keeps strobing through several dark intervals and expects the rear-left lamp to stay lit while the front-left lamp goes dark. A second collision is a cancel event in the same cycle as a right press. For that case the bench expects both turn states clear, so no flashing follows. The only lamps it expects lit are the rear lamps held by the brake.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    typedef enum logic {
        PH_DARK = 1'b0,
        PH_LIT  = 1'b1
    } flash_phase_e;

    typedef struct packed {
        logic emg;
        logic left;
        logic right;
        logic brake;
    } sig_state_t;

    // lamp index order: 0 front-left, 1 front-right, 2 rear-left, 3 rear-right
    localparam int NUM_LAMPS = 4;

    function automatic logic lamp_is_left(input int idx);
        return (idx % 2) == 0;
    endfunction

    function automatic logic lamp_is_rear(input int idx);
        return idx >= 2;
    endfunction

    function automatic logic flash_request(input sig_state_t s);
        return s.emg | s.left | s.right;
    endfunction

endpackage

// File: rtl/tsf_state_reg.sv
module tsf_state_reg
    import tsf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_emg,
    input  logic       ev_left,
    input  logic       ev_right,
    input  logic       ev_cancel,
    input  logic       brake_in,
    output sig_state_t st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.brake <= brake_in;
            if (ev_emg) begin
                st.emg <= ~st.emg;
            end
            if (ev_cancel) begin
                st.left  <= 1'b0;
                st.right <= 1'b0;
            end else begin
                if (ev_left) begin
                    st.left <= 1'b1;
                end
                if (ev_right) begin
                    st.right <= 1'b1;
                end
            end
        end
    end

    p_emg_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        ev_emg |=> (st.emg != $past(st.emg)));

    p_cancel_wins_r3: assert property (@(posedge clk) disable iff (rst)
        ev_cancel |=> (!st.left && !st.right));

    p_left_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_left && !ev_cancel) |=> st.left);

    p_brake_follow_r4: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(brake_in) |=> (st.brake == $past(brake_in)));

endmodule

// File: rtl/tsf_flash_timer.sv
module tsf_flash_timer
    import tsf_pkg::*;
#(
    parameter int LIT_TICKS  = 8,
    parameter int DARK_TICKS = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    output flash_phase_e phase
);

    localparam int MAX_TICKS = (LIT_TICKS > DARK_TICKS) ? LIT_TICKS : DARK_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);
    localparam logic [CW-1:0] LIT_LOAD  = CW'(LIT_TICKS);
    localparam logic [CW-1:0] DARK_LOAD = CW'(DARK_TICKS);
    localparam logic [CW-1:0] LAST      = CW'(1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= PH_DARK;
            cnt   <= LIT_LOAD;
        end else if (tick) begin
            if (cnt <= LAST) begin
                if (phase == PH_DARK) begin
                    phase <= PH_LIT;
                    cnt   <= LIT_LOAD;
                end else begin
                    phase <= PH_DARK;
                    cnt   <= DARK_LOAD;
                end
            end else begin
                cnt <= cnt - LAST;
            end
        end
    end

    p_idle_dark_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == PH_DARK));

    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(phase));

endmodule

// File: rtl/tsf_lamp_mix.sv
module tsf_lamp_mix
    import tsf_pkg::*;
(
    input  sig_state_t                st,
    input  flash_phase_e              phase,
    output logic [NUM_LAMPS-1:0]      lit,
    output logic                      drv_en
);

    for (genvar i = 0; i < NUM_LAMPS; i++) begin : g_lamp
        localparam logic IS_LEFT = lamp_is_left(i);
        localparam logic IS_REAR = lamp_is_rear(i);
        logic flash_src;
        logic gated;

        always_comb begin
            flash_src = st.emg | (IS_LEFT ? st.left : st.right);
            gated     = flash_src & (phase == PH_LIT);
            lit[i]    = gated | (IS_REAR & st.brake);
        end
    end

    assign drv_en = |lit;

endmodule

// File: rtl/turn_flasher_ctrl.sv
module turn_flasher_ctrl
    import tsf_pkg::*;
#(
    parameter int LIT_TICKS  = 8,
    parameter int DARK_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ev_emg,
    input  logic ev_left,
    input  logic ev_right,
    input  logic ev_cancel,
    input  logic brake_in,
    output logic lamp_fl_n,
    output logic lamp_fr_n,
    output logic lamp_rl_n,
    output logic lamp_rr_n,
    output logic drv_en
);

    sig_state_t             st;
    flash_phase_e           phase;
    logic [NUM_LAMPS-1:0]   lit;

    tsf_state_reg u_state (
        .clk       (clk),
        .rst       (rst),
        .ev_emg    (ev_emg),
        .ev_left   (ev_left),
        .ev_right  (ev_right),
        .ev_cancel (ev_cancel),
        .brake_in  (brake_in),
        .st        (st)
    );

    tsf_flash_timer #(
        .LIT_TICKS  (LIT_TICKS),
        .DARK_TICKS (DARK_TICKS)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .run   (flash_request(st)),
        .phase (phase)
    );

    tsf_lamp_mix u_mix (
        .st     (st),
        .phase  (phase),
        .lit    (lit),
        .drv_en (drv_en)
    );

    assign lamp_fl_n = ~lit[0];
    assign lamp_fr_n = ~lit[1];
    assign lamp_rl_n = ~lit[2];
    assign lamp_rr_n = ~lit[3];

    p_brake_rear_r7: assert property (@(posedge clk) disable iff (rst)
        brake_in |=> (!lamp_rl_n && !lamp_rr_n));

    p_dark_off_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DARK && !st.brake) |-> (lamp_fl_n && lamp_fr_n && lamp_rl_n && lamp_rr_n));

    p_drv_match_r10: assert property (@(posedge clk) disable iff (rst)
        drv_en == !(lamp_fl_n && lamp_fr_n && lamp_rl_n && lamp_rr_n));

    p_reset_off_r1: assert property (@(posedge clk)
        rst |=> (lamp_fl_n && lamp_fr_n && lamp_rl_n && lamp_rr_n && !drv_en));

endmodule

// File: tb/turn_flasher_ctrl_bench.sv
module turn_flasher_ctrl_bench;

    localparam int LIT  = 8;
    localparam int DARK = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, ev_emg = 1'b0, ev_left = 1'b0, ev_right = 1'b0;
    logic ev_cancel = 1'b0, brake_in = 1'b0;
    logic lamp_fl_n, lamp_fr_n, lamp_rl_n, lamp_rr_n, drv_en;

    always #5 clk = ~clk;

    turn_flasher_ctrl #(.LIT_TICKS(LIT), .DARK_TICKS(DARK)) u_turn_flasher_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .ev_emg(ev_emg), .ev_left(ev_left),
        .ev_right(ev_right), .ev_cancel(ev_cancel), .brake_in(brake_in),
        .lamp_fl_n(lamp_fl_n), .lamp_fr_n(lamp_fr_n), .lamp_rl_n(lamp_rl_n),
        .lamp_rr_n(lamp_rr_n), .drv_en(drv_en)
    );

    typedef struct {
        logic [4:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model, built from the requirements
    bit m_emg = 0, m_l = 0, m_r = 0, m_brk = 0, m_ph = 0;
    int m_cnt = LIT;

    // {drv_en, fl_n, fr_n, rl_n, rr_n}
    function automatic logic [4:0] model_out();
        bit fl, fr, rl, rr;
        fl = (m_emg | m_l) & m_ph;
        fr = (m_emg | m_r) & m_ph;
        rl = fl | m_brk;
        rr = fr | m_brk;
        return {fl | fr | rl | rr, ~fl, ~fr, ~rl, ~rr};
    endfunction

    task automatic step(input bit t, input bit e, input bit l, input bit r,
                        input bit c, input bit b, input string tag);
        item_t it;
        @(negedge clk);
        tick = t; ev_emg = e; ev_left = l; ev_right = r; ev_cancel = c; brake_in = b;
        @(posedge clk);
        if (!(m_emg | m_l | m_r)) begin
            m_ph  = 0;
            m_cnt = LIT;
        end else if (t) begin
            if (m_cnt == 1) begin
                m_ph  = !m_ph;
                m_cnt = m_ph ? LIT : DARK;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
        m_brk = b;
        if (e) m_emg = !m_emg;
        if (c) begin
            m_l = 0;
            m_r = 0;
        end else begin
            if (l) m_l = 1;
            if (r) m_r = 1;
        end
        it.exp = model_out();
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: pops expected items and compares
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [4:0] act;
            it  = q.pop_front();
            act = {drv_en, lamp_fl_n, lamp_fr_n, lamp_rl_n, lamp_rr_n};
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        item_t it;
        repeat (3) @(posedge clk);
        it.exp = 5'b01111;
        it.tag = "R1 outputs in reset";
        q.push_back(it);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;

        step(0, 0, 0, 0, 0, 0, "R1 idle after reset");
        step(1, 0, 0, 0, 0, 0, "R8 idle with tick stays dark");
        // left press: first dark interval uses lit count
        step(0, 0, 1, 0, 0, 0, "R3 left press sets state");
        for (int i = 0; i < 30; i++) step(1, 0, 0, 0, 0, 0, "R9 left flashing timing R5");
        // no-tick cycles hold phase
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, "R9 phase holds without tick");
        // brake while flashing left: R7 against R6
        for (int i = 0; i < 30; i++) step(1, 0, 0, 0, 0, 1, "R7 brake over dark phase R6");
        // cancel and right press in same cycle
        step(1, 0, 0, 1, 1, 1, "R3 cancel beats right press");
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, 1, "R8 cancelled stays dark R4");
        step(0, 0, 0, 0, 0, 0, "R4 brake release");
        step(0, 0, 0, 0, 0, 0, "R10 all off no drive");
        // right turn
        step(0, 0, 0, 1, 0, 0, "R3 right press sets state");
        for (int i = 0; i < 14; i++) step(1, 0, 0, 0, 0, 0, "R5 right lamps only");
        // emergency on top of right
        step(1, 1, 0, 0, 0, 0, "R2 emergency toggles on");
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0, 0, "R5 emergency all four");
        step(1, 1, 0, 0, 0, 0, "R2 emergency toggles off");
        for (int i = 0; i < 14; i++) step(1, 0, 0, 0, 0, 0, "R5 back to right only");
        step(0, 0, 0, 0, 1, 0, "R3 cancel clears turn");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, "R8 idle dark after cancel");
        // emergency alone, with brake mid-way
        step(0, 1, 0, 0, 0, 0, "R2 emergency on alone");
        for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, (i > 8), "R7 emergency with brake");
        step(0, 1, 0, 0, 0, 0, "R2 emergency off alone");
        step(0, 0, 0, 0, 0, 0, "R10 final off");

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule